// File: doc/BRIEF.md
# Priority Crossbar Pin Assignment Decoder

This block connects a set of internal digital peripheral signals to a bank of general-purpose pads. Software-visible settings arrive as plain inputs: a per-group enable vector, a count for the variable-width capture group, per-pin skip and analog-mode masks, per-pin push-pull/open-drain mode bits, and the GPIO output latches. Every enabled peripheral signal is taken in a fixed priority order. It is placed on the lowest-numbered pad that is still free in the assignable range. Skipping a pin, or enabling or disabling a higher-priority group, therefore moves every signal of lower priority.

Pads that carry no peripheral signal are driven from their GPIO latch. The pad read path always returns the pad level. Peripheral input signals that have no pad read as the idle value 1, and an overflow flag reports that the enabled peripherals need more pins than are free. The whole mapping is combinational. There is no stream data, so no port uses a valid/ready handshake. Every pin here is a plain control or status level.

Top module: `pio_xbar`

## Requirements
- R1: The peripheral signals are numbered 0 to 20 in priority order: group 0 on 0-1, group 1 on 2-5, group 2 on 6-7, group 3 on 8-9, group 4 on 10-11, group 5 on 12, group 6 on 13-18, group 7 on 19-20. Enabled signals go, in increasing signal number, onto free pins in increasing pin number.
- R2: A pin in the assignable range whose skip bit is 1 gets no peripheral signal. It is driven from its GPIO latch.
- R3: A pin whose analog bit is 1 gets no peripheral signal and is never driven (pad_oe 0, pad_out 0). Its read value is 0.
- R4: A group whose grp_en bit is 0 takes no pins. Group 6 uses its lowest cap_cnt signals. A cap_cnt above 6 acts as 6.
- R5: Only pins 0 to 19 can carry peripheral signals. Pins 20 to 24 always behave as GPIO.
- R6: When more signals are enabled than free assignable pins exist, overflow is 1 and the lowest-priority surplus signals stay unassigned. Otherwise overflow is 0.
- R7: An assigned pin takes its value from per_out and its drive request from per_oe of its signal. That signal's per_in returns the pin's read value.
- R8: While xbar_on is 0, every pad_oe and pad_out is 0 and every per_in is 1.
- R9: A push-pull pin (mode bit 1) drives its value whenever the drive request is 1. An open-drain pin (mode bit 0) drives 0 when the value is 0 and releases the pad (pad_oe 0) when the value is 1. pad_out is 0 whenever the mode is open-drain.
- R10: pin_rd equals pad_in for every digital pin, whatever the assignment or xbar_on.
- R11: A GPIO pin requests drive at all times. Its value comes from its latch bit.
- R12: Every unassigned peripheral signal reads per_in 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xbar_on | input | 1 | Global enable of the pad drivers and routing |
| grp_en | input | 8 | Peripheral group enables, bit g for group g |
| cap_cnt | input | 3 | Number of capture signals used by group 6 |
| skip | input | 20 | Skip mask for the assignable pins |
| analog | input | 25 | Analog-mode mask, one bit per pin |
| push_pull | input | 25 | Output mode, 1 push-pull, 0 open-drain |
| latch | input | 25 | GPIO output latch values |
| per_out | input | 21 | Peripheral output value per signal |
| per_oe | input | 21 | Peripheral drive request per signal |
| pad_in | input | 25 | Level seen at each pad |
| pad_out | output | 25 | Value driven onto each pad |
| pad_oe | output | 25 | Drive enable per pad |
| pin_rd | output | 25 | Pad read-back path |
| per_in | output | 21 | Pad levels routed to peripheral inputs |
| overflow | output | 1 | Enabled signals exceed free pins |

## Verification
The bench aims at the shifting cases. One skipped or analog pin must push every later signal up by one. A design that compares against a fixed pin table, or that counts skipped pins as taken, would put later signals on the wrong pads. With 21 signals enabled the last one must fall off and read 1. A design that wraps around or truncates its counts would land that signal on pin 0 or miss the overflow. The bench also covers a cap_cnt of 7 clamped to 6, open-drain release of a logic 1, and a disabled crossbar holding every driver off. A design that ignores any of these would drive a pad that must stay released.

// File: rtl/pio_xbar_pkg.sv
package pio_xbar_pkg;
  localparam int NGRP    = 8;
  localparam int CAP_GRP = 6;
  localparam int CAP_MAX = 6;

  function automatic int grp_width(input int g);
    case (g)
      0: return 2;
      1: return 4;
      2: return 2;
      3: return 2;
      4: return 2;
      5: return 1;
      6: return CAP_MAX;
      default: return 2;
    endcase
  endfunction

  function automatic int grp_base(input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += grp_width(i);
    return acc;
  endfunction

  localparam int NSIG = grp_base(NGRP);
endpackage

// File: rtl/pio_xbar_rank.sv
module pio_xbar_rank #(
  parameter int N = 8,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0]        vec,
  output logic [N-1:0][W-1:0] rank,
  output logic [W-1:0]        total
);
  always_comb begin
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      rank[i] = acc;
      acc     = acc + W'(vec[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/pio_xbar_match.sv
module pio_xbar_match #(
  parameter int NP = 20,
  parameter int NS = 21,
  parameter int RW = 5,
  parameter int PW = $clog2(NP),
  parameter int SW = $clog2(NS)
) (
  input  logic [NP-1:0]         pin_free,
  input  logic [NP-1:0][RW-1:0] pin_rank,
  input  logic [NS-1:0]         sig_en,
  input  logic [NS-1:0][RW-1:0] sig_rank,
  output logic [NP-1:0]         pin_hit,
  output logic [NP-1:0][SW-1:0] pin_sig,
  output logic [NS-1:0]         sig_hit,
  output logic [NS-1:0][PW-1:0] sig_pin
);
  always_comb begin
    pin_hit = '0;
    pin_sig = '0;
    sig_hit = '0;
    sig_pin = '0;
    for (int p = 0; p < NP; p++) begin
      for (int s = 0; s < NS; s++) begin
        if (pin_free[p] && sig_en[s] && (pin_rank[p] == sig_rank[s])) begin
          pin_hit[p] = 1'b1;
          pin_sig[p] = SW'(s);
          sig_hit[s] = 1'b1;
          sig_pin[s] = PW'(p);
        end
      end
    end
  end

  // R1: every placed signal has exactly one pin, and priority order is kept
  always_comb begin
    a_r1_hits_balanced: assert ($countones(pin_hit) == $countones(sig_hit))
      else $error("R1 pin/signal hit counts differ");
    for (int s = 0; s < NS; s++) begin
      for (int t = s + 1; t < NS; t++) begin
        if (sig_hit[s] && sig_hit[t]) begin
          a_r1_order_kept: assert (sig_pin[s] < sig_pin[t])
            else $error("R1 priority order broken");
        end
      end
    end
  end
endmodule

// File: rtl/pio_xbar_pad.sv
module pio_xbar_pad (
  input  logic on,
  input  logic analog,
  input  logic use_per,
  input  logic per_val,
  input  logic per_drv,
  input  logic gpio_val,
  input  logic push_pull,
  output logic pad_out,
  output logic pad_oe
);
  logic val, drv;

  always_comb begin
    val = use_per ? per_val : gpio_val;
    drv = use_per ? per_drv : 1'b1;
    if (!on || analog) begin
      pad_out = 1'b0;
      pad_oe  = 1'b0;
    end else if (push_pull) begin
      pad_out = val;
      pad_oe  = drv;
    end else begin
      pad_out = 1'b0;
      pad_oe  = drv & ~val;
    end
  end
endmodule

// File: rtl/pio_xbar.sv
module pio_xbar #(
  parameter int NUM_PINS  = 25,
  parameter int XBAR_PINS = 20
) (
  input  logic                          xbar_on,
  input  logic [pio_xbar_pkg::NGRP-1:0] grp_en,
  input  logic [2:0]                    cap_cnt,
  input  logic [XBAR_PINS-1:0]          skip,
  input  logic [NUM_PINS-1:0]           analog,
  input  logic [NUM_PINS-1:0]           push_pull,
  input  logic [NUM_PINS-1:0]           latch,
  input  logic [pio_xbar_pkg::NSIG-1:0] per_out,
  input  logic [pio_xbar_pkg::NSIG-1:0] per_oe,
  input  logic [NUM_PINS-1:0]           pad_in,
  output logic [NUM_PINS-1:0]           pad_out,
  output logic [NUM_PINS-1:0]           pad_oe,
  output logic [NUM_PINS-1:0]           pin_rd,
  output logic [pio_xbar_pkg::NSIG-1:0] per_in,
  output logic                          overflow
);
  import pio_xbar_pkg::*;

  localparam int MAXN = (NSIG > XBAR_PINS) ? NSIG : XBAR_PINS;
  localparam int RW   = $clog2(MAXN + 1);
  localparam int PW   = $clog2(XBAR_PINS);
  localparam int SW   = $clog2(NSIG);

  logic [2:0]                   cap_eff;
  logic [NSIG-1:0]              sig_en;
  logic [XBAR_PINS-1:0]         pin_free;
  logic [XBAR_PINS-1:0][RW-1:0] pin_rank;
  logic [NSIG-1:0][RW-1:0]      sig_rank;
  logic [RW-1:0]                pin_total, sig_total;
  logic [XBAR_PINS-1:0]         pin_hit;
  logic [XBAR_PINS-1:0][SW-1:0] pin_sig;
  logic [NSIG-1:0]              sig_hit;
  logic [NSIG-1:0][PW-1:0]      sig_pin;

  assign cap_eff = (cap_cnt > 3'(CAP_MAX)) ? 3'(CAP_MAX) : cap_cnt;

  // Signal enables from group enables (group 6 trimmed by cap count)
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar i = 0; i < grp_width(g); i++) begin : g_bit
      if (g == CAP_GRP) begin : g_cap
        assign sig_en[grp_base(g)+i] = grp_en[g] && (cap_eff > 3'(i));
      end else begin : g_fix
        assign sig_en[grp_base(g)+i] = grp_en[g];
      end
    end
  end

  assign pin_free = ~skip & ~analog[XBAR_PINS-1:0];
  assign pin_rd   = pad_in & ~analog;
  assign overflow = sig_total > pin_total;

  pio_xbar_rank #(.N(XBAR_PINS), .W(RW)) u_pin_rank (
    .vec(pin_free), .rank(pin_rank), .total(pin_total)
  );

  pio_xbar_rank #(.N(NSIG), .W(RW)) u_sig_rank (
    .vec(sig_en), .rank(sig_rank), .total(sig_total)
  );

  pio_xbar_match #(.NP(XBAR_PINS), .NS(NSIG), .RW(RW), .PW(PW), .SW(SW)) u_match (
    .pin_free(pin_free), .pin_rank(pin_rank), .sig_en(sig_en), .sig_rank(sig_rank),
    .pin_hit(pin_hit), .pin_sig(pin_sig), .sig_hit(sig_hit), .sig_pin(sig_pin)
  );

  for (genvar s = 0; s < NSIG; s++) begin : g_in
    assign per_in[s] = (xbar_on && sig_hit[s]) ? pin_rd[sig_pin[s]] : 1'b1;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    logic use_per, per_val, per_drv;
    if (p < XBAR_PINS) begin : g_x
      assign use_per = pin_hit[p];
      assign per_val = per_out[pin_sig[p]];
      assign per_drv = per_oe[pin_sig[p]];
    end else begin : g_gpio
      assign use_per = 1'b0;
      assign per_val = 1'b0;
      assign per_drv = 1'b0;
    end
    pio_xbar_pad u_pad (
      .on(xbar_on), .analog(analog[p]), .use_per(use_per), .per_val(per_val),
      .per_drv(per_drv), .gpio_val(latch[p]), .push_pull(push_pull[p]),
      .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
    );
  end

  always_comb begin
    a_r6_overflow_flag: assert (overflow == ($countones(sig_hit) < $countones(sig_en)))
      else $error("R6 overflow flag disagrees with placement");
    a_r3_analog_quiet: assert (((pad_oe | pin_rd) & analog) == '0)
      else $error("R3 analog pin driven or read nonzero");
    a_r9_od_never_high: assert ((pad_oe & pad_out & ~push_pull) == '0)
      else $error("R9 open-drain pin driving high");
    if (!xbar_on) begin
      a_r8_off_quiet: assert (pad_oe == '0 && per_in == '1)
        else $error("R8 disabled crossbar still active");
    end
  end
endmodule

// File: tb/pio_xbar_tb.sv
module pio_xbar_tb;
  localparam int NP = 25;
  localparam int XP = 20;
  localparam int NS = 21;

  logic          clk = 1'b0;
  logic          xbar_on;
  logic [7:0]    grp_en;
  logic [2:0]    cap_cnt;
  logic [XP-1:0] skip;
  logic [NP-1:0] analog, push_pull, latch, pad_in;
  logic [NS-1:0] per_out, per_oe;
  logic [NP-1:0] pad_out, pad_oe, pin_rd;
  logic [NS-1:0] per_in;
  logic          overflow;

  logic [NP-1:0] e_out, e_oe, e_rd;
  logic [NS-1:0] e_in;
  logic          e_ov;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pio_xbar u_dut (
    .xbar_on(xbar_on), .grp_en(grp_en), .cap_cnt(cap_cnt), .skip(skip),
    .analog(analog), .push_pull(push_pull), .latch(latch), .per_out(per_out),
    .per_oe(per_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_rd(pin_rd), .per_in(per_in), .overflow(overflow)
  );

  // R1/R4 signal table, written from the requirement text
  function automatic bit sig_on(input int s);
    int c;
    c = (cap_cnt > 6) ? 6 : int'(cap_cnt);
    if (s < 2)  return grp_en[0];
    if (s < 6)  return grp_en[1];
    if (s < 8)  return grp_en[2];
    if (s < 10) return grp_en[3];
    if (s < 12) return grp_en[4];
    if (s < 13) return grp_en[5];
    if (s < 19) return grp_en[6] && ((s - 13) < c);
    return grp_en[7];
  endfunction

  task automatic model();
    int sig_of[NP];
    int p;
    bit v, d;
    for (int i = 0; i < NP; i++) sig_of[i] = -1;
    p = 0;
    e_ov = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (sig_on(s)) begin
        while (p < XP && (skip[p] || analog[p])) p++;
        if (p < XP) begin sig_of[p] = s; p++; end
        else e_ov = 1'b1;
      end
    end
    e_rd = pad_in & ~analog;
    e_in = '1;
    for (int q = 0; q < NP; q++) begin
      if (sig_of[q] >= 0) begin
        v = per_out[sig_of[q]];
        d = per_oe[sig_of[q]];
        if (xbar_on) e_in[sig_of[q]] = e_rd[q];
      end else begin
        v = latch[q];
        d = 1'b1;
      end
      if (!xbar_on || analog[q]) begin e_out[q] = 0; e_oe[q] = 0; end
      else if (push_pull[q])     begin e_out[q] = v; e_oe[q] = d; end
      else                       begin e_out[q] = 0; e_oe[q] = d & ~v; end
    end
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle_check(input string tag);
    @(posedge clk); #1;
    model();
    cmp({tag, " pad_out"}, 32'(pad_out), 32'(e_out));
    cmp({tag, " pad_oe"},  32'(pad_oe),  32'(e_oe));
    cmp({tag, " per_in"},  32'(per_in),  32'(e_in));
    cmp({tag, " pin_rd"},  32'(pin_rd),  32'(e_rd));
    cmp({tag, " overflow"}, 32'(overflow), 32'(e_ov));
  endtask

  task automatic rand_data();
    latch   = NP'($urandom);
    pad_in  = NP'($urandom);
    per_out = NS'($urandom);
    per_oe  = NS'($urandom);
  endtask

  task automatic t_reset();  // R8 idle state
    xbar_on = 0; grp_en = 0; cap_cnt = 0; skip = 0; analog = 0;
    push_pull = '1; latch = 0; pad_in = 0; per_out = 0; per_oe = 0;
    settle_check("R8 reset");
    cmp("R8 reset oe zero", 32'(pad_oe), 0);
  endtask

  task automatic t_single_group();  // R1 R4 R7: only group 7 on pins 0,1
    xbar_on = 1; grp_en = 8'h80; per_out = '1; per_oe = '1; pad_in = 25'h2;
    settle_check("R4 single group");
    cmp("R7 sig20 reads pin1", 32'(per_in[20]), 1);
    cmp("R7 pin0 driven", 32'(pad_oe[0] && pad_out[0]), 1);
  endtask

  task automatic t_skip();  // R2 R11
    grp_en = 8'h03; skip = 20'h9; rand_data();
    settle_check("R2 skip shift");
    latch[0] = 1; latch[3] = 0;
    settle_check("R11 skipped pins follow latch");
    cmp("R2 pin0 latch", 32'(pad_out[0]), 1);
  endtask

  task automatic t_analog();  // R3 R10
    skip = 0; analog = 25'h0000102; pad_in = '1; grp_en = 8'h0F;
    settle_check("R3 analog skip");
    cmp("R3 analog reads 0", 32'(pin_rd[1]), 0);
    cmp("R10 digital reads pad", 32'(pin_rd[0]), 1);
    analog = 0;
  endtask

  task automatic t_cap();  // R4 clamp
    grp_en = 8'h40; cap_cnt = 7; rand_data();
    settle_check("R4 cap clamp 7");
    cap_cnt = 3;
    settle_check("R4 cap 3");
    cap_cnt = 0;
    settle_check("R4 cap 0");
  endtask

  task automatic t_overflow();  // R6 R12
    grp_en = 8'hFF; cap_cnt = 6; skip = 0; rand_data();
    settle_check("R6 overflow all");
    cmp("R12 last sig idle", 32'(per_in[20]), 1);
    cmp("R6 flag", 32'(overflow), 1);
    skip = 20'h1;
    settle_check("R6 overflow two");
  endtask

  task automatic t_upper();  // R5
    grp_en = 8'hFF; skip = 20'hFFFFC; rand_data();
    settle_check("R5 upper pins gpio");
    cmp("R5 pin20 oe", 32'(pad_oe[20]), push_pull[20] ? 1 : 32'(~latch[20]));
  endtask

  task automatic t_opendrain();  // R9
    skip = 0; grp_en = 8'h01; push_pull = 0; per_out = 0; per_oe = '1;
    per_out[0] = 1; latch = '1; rand_data(); per_out[0] = 1; per_oe[0] = 1;
    settle_check("R9 open drain");
    cmp("R9 release 1", 32'(pad_oe[0]), 0);
    push_pull = '1;
  endtask

  task automatic t_off();  // R8
    xbar_on = 0; grp_en = 8'hFF; rand_data();
    settle_check("R8 disabled");
    xbar_on = 1;
  endtask

  task automatic t_sweep();  // R1 R2 R7 mixed patterns
    for (int k = 0; k < 40; k++) begin
      grp_en = 8'($urandom); cap_cnt = 3'($urandom); skip = XP'($urandom);
      analog = NP'($urandom) & NP'($urandom); push_pull = NP'($urandom);
      rand_data();
      settle_check("R1 sweep");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single_group();
    t_skip();
    t_analog();
    t_cap();
    t_overflow();
    t_upper();
    t_opendrain();
    t_off();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule